// File: doc/BRIEF.md
# Single-Error-Correcting Memory Read Path

This block guards a 16-bit memory word with five Hamming check bits, A through E, so the word is 21 bits in total. On the write side it forms the check bits with no clock involved. Check bit A is stored in main memory beside the data. Bits B to E go into a separate side array made of four sectors. The sector is picked by the bank bit and the most significant address bit, and the block supplies a one-hot sector strobe for that array.

On the read side the block captures three things in one cycle: the data word, check bit A as it arrives from main memory, and the B..E nibble taken from the addressed sector of the side array. One cycle later the 5-bit error code is latched into the error code register. One cycle after that the corrected word is registered on the output bus. A zero code lets the word through unchanged. A code from 1 to 21 names the single bit position that flipped; if that position holds data, the bit is inverted. A code above 21 cannot come from a single flip, so the word is passed on unchanged.

Normal reads and read-modify-write reads raise an error flag and a write strobe for the error log. Scrub reads correct the word without flagging. The log address packs the sector, the low address bits and the code.

The path has three stages:
- Capture: holds the raw word, the five check bits and the tags.
- Code: holds the error code register and the data.
- Output: holds the corrected word and the flags.

A new read may enter on every cycle.

Top module: `secrp_read_path`

## Requirements
- R1: Code positions run 1 to 21. Check bit A sits at position 1, B at 2, C at 4, D at 8 and E at 16. Data bit k takes the k-th remaining position in ascending order (3, 5, 6, 7, 9, ...). Check bit i, where A=0 and E=4, is the XOR of every data bit whose position has bit i set. `wr_chk_a` is A, and `wr_chk_side[3:0]` is {E,D,C,B}.
- R2: `wr_sector_oh` has exactly bit {wr_bank,wr_amsb} set (bank is the MSB of the index).
- R3: On a read, the check nibble is taken from `rd_side[4s+3:4s]`, where s = {rd_bank,rd_amsb}. The nibbles of the other sectors have no effect on any result.
- R4: A read is presented while `rd_op` is nonzero. `err_code` holds its error code after the second rising edge. The code equals the position of a single flipped bit. It is 0 for an intact word.
- R5: `out_valid` is high for exactly one cycle after the third rising edge. For an intact word, `out_data` then equals the stored data.
- R6: A single flipped data bit is inverted back, so `out_data` equals the original data.
- R7: A single flipped check bit gives code 1, 2, 4, 8 or 16 and leaves the data unchanged.
- R8: A code of 22 to 31 passes the received data unchanged and still counts as an error.
- R9: Op encodings are 00 none, 01 read, 10 read-modify-write and 11 scrub. `out_err` and `log_we` are high with `out_valid` only for op 01 or 10 with a nonzero code. Op 11 corrects the word but never flags.
- R10: `log_addr` = {sector[1:0], rd_alow[2:0], code[4:0]} of the read being output.
- R11: While `rst_n` is low, and after it, `out_valid`, `out_err`, `log_we` and `err_code` are 0. This includes a reset applied while reads are in flight.
- R12: Reads issued on consecutive cycles each produce their own correct result on consecutive cycles, while the write path encodes other data in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 16 | Data word being written |
| wr_bank | input | 1 | Bank bit of the write address |
| wr_amsb | input | 1 | Top address bit of the write address |
| wr_chk_a | output | 1 | Check bit A, stored with the data |
| wr_chk_side | output | 4 | Check bits {E,D,C,B} for the side array |
| wr_sector_oh | output | 4 | One-hot side-array sector strobe |
| rd_op | input | 2 | Read kind: 00 none, 01 read, 10 read-modify-write, 11 scrub |
| rd_bank | input | 1 | Bank bit of the read address |
| rd_amsb | input | 1 | Top address bit of the read address |
| rd_alow | input | 3 | Low address bits used for the log address |
| rd_data | input | 16 | Data word read from main memory |
| rd_chk_a | input | 1 | Check bit A read from main memory |
| rd_side | input | 16 | Side-array read data, four 4-bit sectors |
| err_code | output | 5 | Error code register |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Corrected data word |
| out_err | output | 1 | Error flag for reads and read-modify-writes |
| log_we | output | 1 | Error log write strobe |
| log_addr | output | 10 | Error log address |

## Verification
Two kinds of work can fall in the same cycle. In the first, the write path encodes a fresh word while the read pipeline is correcting an earlier one. In the second, one read is being captured while the read before it is in the code stage and a third is being corrected. The bench provokes both with three back-to-back reads carrying different faults, sectors and ops, while `wr_data` changes every cycle. It judges each output cycle against that read's own expected word, code and flags, and each write-side output against the encoding of the word driven in that cycle.

// File: rtl/secrp_pkg.sv
package secrp_pkg;
    localparam int DATA_W = 16;
    localparam int CHK_W  = 5;
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int SIDE_W = CHK_W - 1;
    localparam int SECT_W = 2;
    localparam int SECT_N = 1 << SECT_W;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_RMW   = 2'b10,
        OP_SCRUB = 2'b11
    } rd_op_e;

    // Code position (1..CW_W) of data bit k: k-th non-power-of-two position.
    function automatic logic [CHK_W-1:0] data_pos(input int k);
        logic [CHK_W-1:0] res;
        int cnt;
        res = '0;
        cnt = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == k) res = CHK_W'(p);
                cnt++;
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/secrp_encoder.sv
module secrp_encoder
    import secrp_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    always_comb begin
        chk_o = '0;
        for (int k = 0; k < DATA_W; k++) begin
            for (int i = 0; i < CHK_W; i++) begin
                if (data_pos(k)[i]) chk_o[i] = chk_o[i] ^ data_i[k];
            end
        end
    end
endmodule

// File: rtl/secrp_sector_dec.sv
module secrp_sector_dec
    import secrp_pkg::*;
(
    input  logic [SECT_W-1:0] idx_i,
    output logic [SECT_N-1:0] onehot_o
);
    for (genvar g = 0; g < SECT_N; g++) begin : g_sect
        assign onehot_o[g] = (idx_i == SECT_W'(g));
    end
endmodule

// File: rtl/secrp_sector_mux.sv
module secrp_sector_mux
    import secrp_pkg::*;
(
    input  logic [SECT_W-1:0]        idx_i,
    input  logic [SECT_N*SIDE_W-1:0] bus_i,
    output logic [SIDE_W-1:0]        nib_o
);
    always_comb begin
        nib_o = '0;
        for (int s = 0; s < SECT_N; s++) begin
            if (idx_i == SECT_W'(s)) nib_o = bus_i[s*SIDE_W +: SIDE_W];
        end
    end
endmodule

// File: rtl/secrp_corrector.sv
module secrp_corrector
    import secrp_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  code_i,
    output logic [DATA_W-1:0] data_o
);
    // Only a code equal to a data position inverts a bit; at most one match.
    always_comb begin
        data_o = data_i;
        for (int k = 0; k < DATA_W; k++) begin
            if (code_i == data_pos(k)) data_o[k] = ~data_i[k];
        end
    end
endmodule

// File: rtl/secrp_read_path.sv
module secrp_read_path
    import secrp_pkg::*;
#(
    parameter int LOW_W = 3,
    localparam int LOG_W = SECT_W + LOW_W + CHK_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     wr_bank,
    input  logic                     wr_amsb,
    output logic                     wr_chk_a,
    output logic [SIDE_W-1:0]        wr_chk_side,
    output logic [SECT_N-1:0]        wr_sector_oh,
    input  logic [1:0]               rd_op,
    input  logic                     rd_bank,
    input  logic                     rd_amsb,
    input  logic [LOW_W-1:0]         rd_alow,
    input  logic [DATA_W-1:0]        rd_data,
    input  logic                     rd_chk_a,
    input  logic [SECT_N*SIDE_W-1:0] rd_side,
    output logic [CHK_W-1:0]         err_code,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic                     out_err,
    output logic                     log_we,
    output logic [LOG_W-1:0]         log_addr
);
    // ---------------- write path ----------------
    logic [CHK_W-1:0] wr_chk;

    secrp_encoder enc_wr_i (.data_i(wr_data), .chk_o(wr_chk));
    assign wr_chk_a    = wr_chk[0];
    assign wr_chk_side = wr_chk[CHK_W-1:1];

    secrp_sector_dec dec_wr_i (.idx_i({wr_bank, wr_amsb}), .onehot_o(wr_sector_oh));

    // ---------------- capture stage ----------------
    rd_op_e             rd_op_t;
    logic [SIDE_W-1:0]  rd_nib;
    logic               s1_v;
    rd_op_e             s1_op;
    logic [DATA_W-1:0]  s1_data;
    logic [CHK_W-1:0]   s1_chk;
    logic [SECT_W-1:0]  s1_sect;
    logic [LOW_W-1:0]   s1_low;

    assign rd_op_t = rd_op_e'(rd_op);

    secrp_sector_mux mux_rd_i (.idx_i({rd_bank, rd_amsb}), .bus_i(rd_side), .nib_o(rd_nib));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_op   <= OP_NONE;
            s1_data <= '0;
            s1_chk  <= '0;
            s1_sect <= '0;
            s1_low  <= '0;
        end else begin
            s1_v <= (rd_op_t != OP_NONE);
            if (rd_op_t != OP_NONE) begin
                s1_op   <= rd_op_t;
                s1_data <= rd_data;
                s1_chk  <= {rd_nib, rd_chk_a};
                s1_sect <= {rd_bank, rd_amsb};
                s1_low  <= rd_alow;
            end
        end
    end

    // ---------------- code stage ----------------
    logic [CHK_W-1:0]   s1_recalc;
    logic [CHK_W-1:0]   syndrome;
    logic               s2_v;
    rd_op_e             s2_op;
    logic [DATA_W-1:0]  s2_data;
    logic [CHK_W-1:0]   code_q;
    logic [SECT_W-1:0]  s2_sect;
    logic [LOW_W-1:0]   s2_low;

    secrp_encoder enc_rd_i (.data_i(s1_data), .chk_o(s1_recalc));
    assign syndrome = s1_recalc ^ s1_chk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_op   <= OP_NONE;
            s2_data <= '0;
            code_q  <= '0;
            s2_sect <= '0;
            s2_low  <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_op   <= s1_op;
                s2_data <= s1_data;
                code_q  <= syndrome;
                s2_sect <= s1_sect;
                s2_low  <= s1_low;
            end
        end
    end

    assign err_code = code_q;

    // ---------------- output stage ----------------
    logic [DATA_W-1:0] fixed;
    logic              flag_d;

    secrp_corrector corr_i (.data_i(s2_data), .code_i(code_q), .data_o(fixed));

    always_comb begin
        unique case (s2_op)
            OP_READ, OP_RMW:   flag_d = s2_v && (code_q != '0);
            OP_NONE, OP_SCRUB: flag_d = 1'b0;
            default:           flag_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
            log_we    <= 1'b0;
            log_addr  <= '0;
        end else begin
            out_valid <= s2_v;
            out_err   <= flag_d;
            log_we    <= flag_d;
            if (s2_v) begin
                out_data <= fixed;
                log_addr <= {s2_sect, s2_low, code_q};
            end
        end
    end

    // ---------------- assertions ----------------
    a_r2_sector_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_sector_oh) == 1);

    a_r9_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);

    a_r9_scrub_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && s2_op == OP_SCRUB) |=> !out_err && !log_we);

    a_r5_clean_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && code_q == '0) |=> (out_data == $past(s2_data)) && !out_err);

    a_r7_check_flip_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && $countones(code_q) == 1) |=> out_data == $past(s2_data));

    a_r8_multi_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && code_q > CHK_W'(CW_W)) |=> out_data == $past(s2_data));

    a_r10_log_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        log_we |-> log_addr[CHK_W-1:0] != '0);

    a_r5_valid_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |=> s2_v);
endmodule

// File: tb/secrp_read_path_tb.sv
module secrp_read_path_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_bank = 1'b0, wr_amsb = 1'b0;
    logic        wr_chk_a;
    logic [3:0]  wr_chk_side, wr_sector_oh;
    logic [1:0]  rd_op = 2'b00;
    logic        rd_bank = 1'b0, rd_amsb = 1'b0;
    logic [2:0]  rd_alow = '0;
    logic [15:0] rd_data = '0;
    logic        rd_chk_a = 1'b0;
    logic [15:0] rd_side = '0;
    logic [4:0]  err_code;
    logic        out_valid, out_err, log_we;
    logic [15:0] out_data;
    logic [9:0]  log_addr;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    secrp_read_path dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_data(wr_data), .wr_bank(wr_bank), .wr_amsb(wr_amsb),
        .wr_chk_a(wr_chk_a), .wr_chk_side(wr_chk_side), .wr_sector_oh(wr_sector_oh),
        .rd_op(rd_op), .rd_bank(rd_bank), .rd_amsb(rd_amsb), .rd_alow(rd_alow),
        .rd_data(rd_data), .rd_chk_a(rd_chk_a), .rd_side(rd_side),
        .err_code(err_code), .out_valid(out_valid), .out_data(out_data),
        .out_err(out_err), .log_we(log_we), .log_addr(log_addr)
    );

    // {data16, flipA5, flipB5, op2, sector2, low3}
    localparam int NV = 12;
    localparam logic [32:0] VEC [NV] = '{
        {16'hA5A5, 5'd0,  5'd0,  2'b01, 2'd0, 3'd1},
        {16'h1234, 5'd3,  5'd0,  2'b01, 2'd1, 3'd2},
        {16'hFFFF, 5'd21, 5'd0,  2'b10, 2'd2, 3'd7},
        {16'h0000, 5'd12, 5'd0,  2'b01, 2'd3, 3'd0},
        {16'hBEEF, 5'd1,  5'd0,  2'b01, 2'd0, 3'd5},
        {16'hC0DE, 5'd2,  5'd0,  2'b10, 2'd1, 3'd3},
        {16'h5555, 5'd16, 5'd0,  2'b01, 2'd2, 3'd4},
        {16'h8001, 5'd8,  5'd0,  2'b01, 2'd3, 3'd6},
        {16'h0F0F, 5'd20, 5'd3,  2'b01, 2'd1, 3'd1},
        {16'h7777, 5'd17, 5'd12, 2'b10, 2'd2, 3'd2},
        {16'h1357, 5'd9,  5'd0,  2'b11, 2'd3, 3'd5},
        {16'h2468, 5'd4,  5'd0,  2'b11, 2'd0, 3'd0}
    };

    function automatic logic [20:0] tb_cw(input logic [15:0] d);
        logic [20:0] cw;
        int k;
        cw = '0;
        k = 0;
        for (int p = 1; p <= 21; p++)
            if ((p & (p - 1)) != 0) begin cw[p-1] = d[k]; k++; end
        for (int i = 0; i < 5; i++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= 21; p++)
                if (((p & (p - 1)) != 0) && p[i]) par = par ^ cw[p-1];
            cw[(1 << i) - 1] = par;
        end
        return cw;
    endfunction

    function automatic logic [15:0] tb_data(input logic [20:0] cw);
        logic [15:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= 21; p++)
            if ((p & (p - 1)) != 0) begin d[k] = cw[p-1]; k++; end
        return d;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        logic [15:0] data;
        logic [4:0]  code;
        logic        err;
        logic [9:0]  laddr;
    } exp_t;

    // Drive one read's inputs from a vector and return expectations.
    task automatic drive_read(input logic [32:0] v, output exp_t e);
        logic [15:0] d;
        logic [4:0] fa, fb, code;
        logic [1:0] op, sec;
        logic [2:0] low;
        logic [20:0] cw, rx, fx;
        logic [3:0] nib;
        {d, fa, fb, op, sec, low} = v;
        cw = tb_cw(d);
        rx = cw;
        if (fa != 0) rx[fa-1] = ~rx[fa-1];
        if (fb != 0) rx[fb-1] = ~rx[fb-1];
        code = fa ^ fb;
        fx = rx;
        if (code >= 1 && code <= 21) fx[code-1] = ~fx[code-1];
        nib = {rx[15], rx[7], rx[3], rx[1]};
        rd_op    = op;
        rd_bank  = sec[1];
        rd_amsb  = sec[0];
        rd_alow  = low;
        rd_data  = tb_data(rx);
        rd_chk_a = rx[0];
        rd_side  = {4{~nib}};
        rd_side[sec*4 +: 4] = nib;
        e.data  = tb_data(fx);
        e.code  = code;
        e.err   = (code != 0) && (op == 2'b01 || op == 2'b10);
        e.laddr = {sec, low, code};
    endtask

    task automatic check_out(input exp_t e, input string tag);
        check(out_valid === 1'b1, {tag, " R5 out_valid"}, 32'(out_valid), 32'd1);
        check(out_data === e.data, {tag, " R6/R7/R8 out_data"}, 32'(out_data), 32'(e.data));
        check(out_err === e.err && log_we === e.err, {tag, " R9 out_err/log_we"},
              32'({out_err, log_we}), 32'({e.err, e.err}));
        if (e.err) check(log_addr === e.laddr, {tag, " R10 log_addr"}, 32'(log_addr), 32'(e.laddr));
    endtask

    task automatic check_write(input logic [15:0] d, input logic [1:0] sec);
        logic [20:0] cw;
        cw = tb_cw(d);
        check(wr_chk_a === cw[0] && wr_chk_side === {cw[15], cw[7], cw[3], cw[1]},
              "R1 write check bits", 32'({wr_chk_side, wr_chk_a}),
              32'({cw[15], cw[7], cw[3], cw[1], cw[0]}));
        check(wr_sector_oh === 4'(1 << sec), "R2 sector strobe", 32'(wr_sector_oh), 32'(1 << sec));
    endtask

    initial begin
        exp_t e;
        exp_t eq [3];
        // R11: reset state
        repeat (3) @(negedge clk);
        check(out_valid === 0 && out_err === 0 && log_we === 0 && err_code === 0,
              "R11 reset state", 32'({out_valid, out_err, log_we, err_code}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 0, "R11 idle after reset", 32'(out_valid), 32'd0);

        // R1/R2 write path
        for (int w = 0; w < 8; w++) begin
            wr_data = 16'h1 << (w * 2) ^ 16'h9C3A * w;
            {wr_bank, wr_amsb} = 2'(w);
            #1;
            check_write(wr_data, 2'(w));
            @(negedge clk);
        end

        // Table walk: R3..R10
        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            drive_read(VEC[n], e);
            @(negedge clk);
            rd_op = 2'b00;
            rd_side = 16'h0;
            @(negedge clk);
            check(err_code === e.code, $sformatf("vec%0d R4/R3 err_code", n), 32'(err_code), 32'(e.code));
            @(negedge clk);
            check_out(e, $sformatf("vec%0d", n));
            @(negedge clk);
            check(out_valid === 0 && out_err === 0, $sformatf("vec%0d R5 single-cycle valid", n),
                  32'({out_valid, out_err}), 32'd0);
        end

        // R12: back-to-back reads with concurrent writes
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (c >= 3) check_out(eq[c-3], $sformatf("b2b%0d R12", c - 3));
            if (c < 3) drive_read(VEC[(c * 4 + 1) % NV], eq[c]);
            else rd_op = 2'b00;
            wr_data = 16'hF00D + 16'(c * 16'h1111);
            {wr_bank, wr_amsb} = 2'(3 - (c % 4));
            #1;
            check_write(wr_data, 2'(3 - (c % 4)));
        end

        // R11: reset with reads in flight
        @(negedge clk);
        drive_read(VEC[1], e);
        @(negedge clk);
        drive_read(VEC[9], e);
        @(negedge clk);
        rd_op = 2'b00;
        rst_n = 1'b0;
        #1;
        check(out_valid === 0 && out_err === 0 && log_we === 0 && err_code === 0,
              "R11 reset in flight", 32'({out_valid, out_err, log_we, err_code}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid === 0 && err_code === 0, "R11 pipeline flushed",
              32'({out_valid, err_code}), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule